// File: doc/BRIEF.md
# Filtered Shift-Register Keystream Core with Key/IV Warmup

This block holds a 192-bit binary shift register and passes thirteen of its bits through a nonlinear filter. The filter output is XORed with one more register bit, which gives one filtered bit per step. A start pulse fills the register from an 80-bit key and a 64-bit IV using a fixed mixing pattern. The block then runs a warmup of 768 steps on its own, one per clock. During warmup the filtered bit is folded into the feedback, and no output is produced.

When warmup ends, the block raises `ready`. From then on the feedback is purely linear. Each cycle with `advance` high emits one filtered bit, flagged by `yValid`, and steps the register once. A downstream decimator and rate buffer consume this bit stream; they are not part of this block.

Top module: `filtLfsrCore`

## Requirements
- R1: While `rstN` is low and after reset, `ready` and `yValid` are 0 until a warmup has completed.
- R2: A `start` pulse loads state bit x_i (i = 0..191) as follows, where K_n is `keyIn[n]` and V_n is `ivIn[n]`. For 0≤i≤79, x_i = K_i. For 80≤i≤143, x_i = K_(i-80) ^ V_(i-80). For 144≤i≤159, x_i = K_(i-80) ^ V_(i-144) ^ V_(i-128) ^ V_(i-112) ^ V_(i-96). For 160≤i≤191, x_i = V_(i-160) ^ V_(i-128) ^ 1.
- R3: After the loading edge, the register steps on exactly the next 768 clock edges. `ready` reads 1 only after the 768th of these edges.
- R4: During warmup the new bit is the linear feedback XOR the filtered bit y. `yValid` stays 0 and `advance` has no effect.
- R5: Each step shifts toward x0 and puts the new bit in x191. The linear feedback is x0^x5^x16^x17^x46^x77^x94^x131^x132^x155^x156^x169^x188^x189.
- R6: In the ready state, a clock edge with `advance` high sets `yOut` to the y of the state before the step. The same edge raises `yValid` for one cycle and steps the register with linear feedback only.
- R7: In the ready state, a clock edge with `advance` low leaves the state unchanged and drives `yValid` to 0.
- R8: The filtered bit is y = f(x191,x186,x178,x172,x162,x144,x111,x104,x65,x54,x45,x28,x13) ^ x1. Here f is the XOR of all pairwise ANDs of its 13 inputs, XORed with the XOR of all 13 inputs.
- R9: A `start` pulse in any phase reloads the register and restarts the warmup count from zero. `ready` is 0 after that edge.
- R10: When `start` and `advance` are high on the same edge, `start` wins: no bit is emitted and `yValid` is 0 after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| keyIn | input | 80 | Key, bit n is K_n |
| ivIn | input | 64 | IV, bit n is V_n |
| start | input | 1 | Load and begin warmup |
| advance | input | 1 | Request one output step in the ready state |
| yOut | output | 1 | Last emitted filtered bit |
| yValid | output | 1 | yOut was emitted on the last edge |
| ready | output | 1 | Warmup complete, outputs may be requested |

## Verification
Some properties are checked on every cycle:
- the warmup counter stays inside its range;
- a start edge always drops `ready`;
- a valid output only follows a ready, non-start advance;
- the state holds whenever no step strobe is raised;
- the nonlinear and emit strobes never coincide.

Other behaviour only shows up over whole scenarios, and the bench covers it:
- the loaded key/IV mixing;
- the exact 768-cycle warmup length;
- the filter value;
- restarts during warmup and during run.

The bench checks these against its own model of the register, filter and load pattern.

// File: rtl/filtLfsrPkg.sv
package filtLfsrPkg;
  localparam int STATE_W   = 192;
  localparam int KEY_W     = 80;
  localparam int IV_W      = 64;
  localparam int FILT_N    = 13;
  localparam int FB_N      = 13;
  localparam int WARM_MULT = 4;

  // filter taps (order irrelevant for a symmetric function)
  localparam int FILT_TAPS [FILT_N] = '{191, 186, 178, 172, 162, 144, 111, 104, 65, 54, 45, 28, 13};
  localparam int LIN_TAP = 1;
  // feedback taps besides x0
  localparam int FB_TAPS [FB_N] = '{189, 188, 169, 156, 155, 132, 131, 94, 77, 46, 17, 16, 5};

  typedef struct packed {
    logic load;    // reload state from key/IV
    logic shift;   // step the register
    logic nonlin;  // fold filter output into feedback
    logic emit;    // capture filtered bit to output
  } ctlStrobeT;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_WARM = 2'd1,
    PH_RUN  = 2'd2
  } phaseT;
endpackage

// File: rtl/filtStage.sv
module filtStage
  import filtLfsrPkg::*;
(
  input  logic [STATE_W-1:0] stateIn,
  output logic               yBit
);
  localparam int WCNT_W = $clog2(FILT_N + 1);

  logic [FILT_N-1:0] tapBits;
  logic [WCNT_W-1:0] weight;

  for (genvar g = 0; g < FILT_N; g++) begin : g_tap
    assign tapBits[g] = stateIn[FILT_TAPS[g]];
  end

  always_comb begin
    weight = '0;
    for (int i = 0; i < FILT_N; i++) begin
      weight = weight + WCNT_W'(tapBits[i]);
    end
  end

  // quadratic symmetric f: 1 when weight mod 4 is 1 or 2
  assign yBit = (weight[1] ^ weight[0]) ^ stateIn[LIN_TAP];
endmodule

// File: rtl/filtLfsrCtl.sv
module filtLfsrCtl
  import filtLfsrPkg::*;
#(
  parameter int WARM_CYCLES = WARM_MULT * STATE_W
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      start,
  input  logic      advance,
  output ctlStrobeT strobes,
  output logic      ready
);
  localparam int CNT_W = $clog2(WARM_CYCLES);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WARM_CYCLES - 1);

  phaseT           phaseQ;
  logic [CNT_W-1:0] cntQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phaseQ <= PH_IDLE;
      cntQ   <= '0;
    end else if (start) begin
      phaseQ <= PH_WARM;
      cntQ   <= '0;
    end else if (phaseQ == PH_WARM) begin
      if (cntQ == CNT_LAST) begin
        phaseQ <= PH_RUN;
        cntQ   <= '0;
      end else begin
        cntQ <= cntQ + 1'b1;
      end
    end
  end

  always_comb begin
    strobes.load   = start;
    strobes.nonlin = (phaseQ == PH_WARM) && !start;
    strobes.emit   = (phaseQ == PH_RUN) && advance && !start;
    strobes.shift  = strobes.nonlin || strobes.emit;
  end

  assign ready = (phaseQ == PH_RUN);

  // R3
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    (phaseQ != PH_WARM) |-> (cntQ == '0));

  // R9
  start_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    start |=> (!ready && cntQ == '0));

  // R3
  ready_entry_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ready) |-> ($past(phaseQ) == PH_WARM));
endmodule

// File: rtl/filtLfsrPath.sv
module filtLfsrPath
  import filtLfsrPkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [KEY_W-1:0]   keyIn,
  input  logic [IV_W-1:0]    ivIn,
  input  ctlStrobeT          strobes,
  output logic               yOut,
  output logic               yValid
);
  logic [STATE_W-1:0] stateQ;
  logic [STATE_W-1:0] loadVal;
  logic               yComb;
  logic               linFb;
  logic               newBit;

  filtStage u_filt (
    .stateIn (stateQ),
    .yBit    (yComb)
  );

  always_comb begin
    linFb = stateQ[0];
    for (int i = 0; i < FB_N; i++) begin
      linFb = linFb ^ stateQ[FB_TAPS[i]];
    end
    newBit = linFb ^ (strobes.nonlin & yComb);
  end

  // key/IV mixing
  always_comb begin
    for (int i = 0; i < STATE_W; i++) begin
      if (i < 80)
        loadVal[i] = keyIn[i];
      else if (i < 144)
        loadVal[i] = keyIn[i-80] ^ ivIn[i-80];
      else if (i < 160)
        loadVal[i] = keyIn[i-80] ^ ivIn[i-144] ^ ivIn[i-128] ^ ivIn[i-112] ^ ivIn[i-96];
      else
        loadVal[i] = ivIn[i-160] ^ ivIn[i-128] ^ 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= '0;
      yOut   <= 1'b0;
      yValid <= 1'b0;
    end else begin
      if (strobes.load)
        stateQ <= loadVal;
      else if (strobes.shift)
        stateQ <= {newBit, stateQ[STATE_W-1:1]};
      yValid <= strobes.emit;
      if (strobes.emit)
        yOut <= yComb;
    end
  end

  // R7
  hold_state_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.load && !strobes.shift) |=> $stable(stateQ));

  // R4
  warm_no_emit_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(strobes.nonlin && strobes.emit));

  // R5
  shift_dir_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.shift && !strobes.load) |=> (stateQ[STATE_W-2:0] == $past(stateQ[STATE_W-1:1])));
endmodule

// File: rtl/filtLfsrCore.sv
module filtLfsrCore
  import filtLfsrPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [79:0] keyIn,
  input  logic [63:0] ivIn,
  input  logic        start,
  input  logic        advance,
  output logic        yOut,
  output logic        yValid,
  output logic        ready
);
  ctlStrobeT strobes;

  filtLfsrCtl u_ctl (
    .clk     (clk),
    .rstN    (rstN),
    .start   (start),
    .advance (advance),
    .strobes (strobes),
    .ready   (ready)
  );

  filtLfsrPath u_path (
    .clk     (clk),
    .rstN    (rstN),
    .keyIn   (keyIn),
    .ivIn    (ivIn),
    .strobes (strobes),
    .yOut    (yOut),
    .yValid  (yValid)
  );

  // R6 R10
  valid_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    yValid |-> $past(ready && advance && !start));

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !$past(rstN) |-> (!ready && !yValid));
endmodule

// File: tb/test_filtLfsrCore.sv
module test_filtLfsrCore;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [79:0] keyIn = '0;
  logic [63:0] ivIn = '0;
  logic        start = 1'b0;
  logic        advance = 1'b0;
  logic        yOut, yValid, ready;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  logic [191:0] refS;

  always #2 clk = ~clk;  // 250 MHz

  filtLfsrCore i_filtLfsrCore (
    .clk(clk), .rstN(rstN), .keyIn(keyIn), .ivIn(ivIn),
    .start(start), .advance(advance),
    .yOut(yOut), .yValid(yValid), .ready(ready)
  );

  // {key, iv, advance pattern}
  localparam int NVEC = 4;
  localparam logic [159:0] VECS [NVEC] = '{
    {80'h0, 64'h0, 16'hFFFF},
    {80'hFFFF_FFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 16'hA5A5},
    {80'h0123_4567_89AB_CDEF_1357, 64'hFEDC_BA98_7654_3210, 16'h0F3C},
    {80'h8000_0000_0000_0000_0001, 64'h0000_0001_8000_0000, 16'hFFF0}
  };

  function automatic logic [191:0] refLoad(input logic [79:0] k, input logic [63:0] v);
    logic [191:0] s;
    for (int i = 0; i < 80; i++)    s[i] = k[i];
    for (int i = 80; i < 144; i++)  s[i] = k[i-80] ^ v[i-80];
    for (int i = 144; i < 160; i++) s[i] = k[i-80] ^ v[i-144] ^ v[i-128] ^ v[i-112] ^ v[i-96];
    for (int i = 160; i < 192; i++) s[i] = ~(v[i-160] ^ v[i-128]);
    return s;
  endfunction

  function automatic logic refY(input logic [191:0] s);
    int tp [13] = '{191, 186, 178, 172, 162, 144, 111, 104, 65, 54, 45, 28, 13};
    logic acc = 1'b0;
    for (int i = 0; i < 13; i++) begin
      acc ^= s[tp[i]];
      for (int j = i + 1; j < 13; j++) acc ^= s[tp[i]] & s[tp[j]];
    end
    return acc ^ s[1];
  endfunction

  function automatic logic [191:0] refStep(input logic [191:0] s, input bit nl);
    logic lin;
    lin = s[189]^s[188]^s[169]^s[156]^s[155]^s[132]^s[131]^s[94]^s[77]^s[46]^s[17]^s[16]^s[5]^s[0];
    if (nl) lin ^= refY(s);
    return {lin, s[191:1]};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // start a load at a negedge and walk the warmup; advDuring toggles advance
  task automatic doWarm(input logic [79:0] k, input logic [63:0] v, input bit advDuring);
    keyIn = k; ivIn = v; start = 1'b1;
    @(negedge clk);
    start = 1'b0; advance = advDuring;
    chk("R9", ready, 0);
    chk("R10", yValid, 0);
    for (int n = 1; n <= 768; n++) begin
      @(negedge clk);
      chk("R3", ready, (n == 768));
      chk("R4", yValid, 0);
      advance = advDuring & n[0];
    end
    advance = 1'b0;
    refS = refLoad(k, v);
    for (int n = 0; n < 768; n++) refS = refStep(refS, 1'b1);
  endtask

  task automatic runSteps(input logic [15:0] pat, input int reps);
    for (int r = 0; r < reps; r++) begin
      for (int i = 0; i < 16; i++) begin
        advance = pat[i];
        @(negedge clk);
        if (pat[i]) begin
          chk("R6", yValid, 1);
          chk("R8 R5 R2", yOut, refY(refS));
          refS = refStep(refS, 1'b0);
        end else begin
          chk("R7", yValid, 0);
        end
      end
    end
    advance = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", ready, 0);
    chk("R1", yValid, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1", ready, 0);
    chk("R1", yValid, 0);

    // vector table: load, warmup, run
    for (int vI = 0; vI < NVEC; vI++) begin
      doWarm(VECS[vI][159:80], VECS[vI][79:16], vI[0]);
      runSteps(VECS[vI][15:0], 2);
    end

    // restart in the middle of warmup
    keyIn = 80'h5555_AAAA_5555_AAAA_5555; ivIn = 64'h3333_CCCC_3333_CCCC; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (300) @(negedge clk);
    chk("R9", ready, 0);
    doWarm(80'h1111_2222_3333_4444_5555, 64'h6666_7777_8888_9999, 1'b0);
    runSteps(16'hFFFF, 1);

    // restart while running, with advance held high on the start edge
    advance = 1'b1;
    doWarm(80'hDEAD_BEEF_0000_1234_5678, 64'hCAFE_F00D_0BAD_C0DE, 1'b1);
    runSteps(16'h8001, 2);

    // reset while running
    advance = 1'b1;
    rstN = 1'b0;
    @(negedge clk);
    chk("R1", ready, 0);
    chk("R1", yValid, 0);
    rstN = 1'b1; advance = 1'b0;
    @(negedge clk);
    chk("R1", ready, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule